// File: doc/BRIEF.md
# PCI Host Bridge Window Register Bank

This block is the processor-side register file of a PCI host bridge. A 32-bit processor bus reaches it through a single-cycle request port. Behind that port sit one configuration-address register, four outbound translation windows, three inbound translation windows and a gasket timer. Each window is a 32-byte slot that holds up to four 32-bit settings. The block only stores these settings and returns them on reads. It translates no addresses and drives no PCI signals. Forwarding of configuration data onto the PCI bus is handled elsewhere, so the data-port offset 0x004 reads as zero here.

Decoding has two levels. Address bits [11:5] are compared with the base of each slot. Bits [4:2] then pick a register inside the chosen slot. Offsets that match no register read as zero, and writes to them change nothing. A small interrupt router sits next to the registers. It rotates the four interrupt pins of the two expansion-slot devices onto four host interrupt lines.

Top module: `pcib_winregs`

## Requirements
- R1: After a synchronous reset every register reads as zero, and `rsp_rdata` and `irq_line` are zero.
- R2: `rsp_rdata` updates on the clock edge that samples a read request (`req_valid`=1, `req_write`=0). It keeps its value across write cycles and idle cycles.
- R3: The configuration-address register is at offset 0x000. A write stores the data with bits [1:0] forced to 0, and a read returns the stored value.
- R4: Outbound window k (k=0..3) has its slot base at 0xC20+0x20*k. Its registers are at +0x0, +0x4, +0x8 and +0x10, which are register indices 0, 1, 2 and 4 in address bits [4:2]. Each register has its own storage and can be read and written.
- R5: Inbound windows 1, 2 and 3 have slot bases 0xDE0, 0xDC0 and 0xDA0. Their registers are at +0x0, +0x8, +0xC and +0x10, which are indices 0, 2, 3 and 4. Each register has its own storage and can be read and written.
- R6: Inside a window slot, the register at +0x10 and the register at +0x0 are separate. A write to one never changes the other.
- R7: The gasket timer is a full 32-bit read/write register at offset 0xE20. It is decoded only at that word.
- R8: Any offset not listed in R3 to R7 reads as zero, and a write to it changes no register. This includes 0x004, outbound +0xC, inbound +0x4, indices 5 to 7 of any slot, and 0xE24 to 0xE3C.
- R9: Address bits [1:0] take no part in decoding. Every access moves a full 32-bit word.
- R10: The device number is `irq_devfn`[7:3]. For devices 0x11 and 0x12, `irq_line` becomes (`irq_pin` + devno − 0x10) mod 4, one clock after the inputs are sampled.
- R11: For any other device number, `irq_line` becomes 0 one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the register block |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data, one cycle after a read |
| irq_devfn | input | 8 | Device/function number of the interrupting device |
| irq_pin | input | 2 | Interrupt pin of that device, 0 to 3 for A to D |
| irq_line | output | 2 | Host interrupt line that the pin is routed to (registered) |

## Verification
Each register has its own storage, so a fault in decode or storage does not appear at the ports until a later read. A stored value that is wrong, aliased or lost shows up on `rsp_rdata` one cycle after the first read of the affected word. Depending on what the software reads, that may be many cycles after the bad write. For this reason the random phase is followed by a sweep that reads every word offset and compares it with a model. Faults in the interrupt rotation appear on `irq_line` one cycle after the device and pin inputs are applied.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int OFS_W     = 12;
  localparam int FIELD_W   = 3;
  localparam int N_FIELDS  = 5;
  localparam int SLOT_LSB  = 5;

  // bit f set: register index f exists in the slot
  localparam logic [N_FIELDS-1:0] OUT_FIELDS = 5'b10111;
  localparam logic [N_FIELDS-1:0] IN_FIELDS  = 5'b11101;
  localparam logic [N_FIELDS-1:0] TMR_FIELDS = 5'b00001;

  localparam logic [OFS_W-1:0] OUT_BASE0   = 12'hC20;
  localparam logic [OFS_W-1:0] IN_BASE0    = 12'hDE0;
  localparam logic [OFS_W-1:0] TMR_OFS     = 12'hE20;
  localparam logic [OFS_W-1:0] SLOT_STRIDE = 12'h020;

  // outbound slots ascend from the first base
  function automatic logic [OFS_W-1:0] out_base(input int k);
    return OUT_BASE0 + SLOT_STRIDE * OFS_W'(k);
  endfunction

  // inbound windows are numbered downward in address
  function automatic logic [OFS_W-1:0] in_base(input int k);
    return IN_BASE0 - SLOT_STRIDE * OFS_W'(k);
  endfunction
endpackage

// File: rtl/pcib_addr_dec.sv
module pcib_addr_dec
  import pcib_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 3
) (
  input  logic [OFS_W-1:0]   addr,
  output logic [N_OUT-1:0]   out_hit,
  output logic [N_IN-1:0]    in_hit,
  output logic               tmr_hit,
  output logic               cfg_hit,
  output logic [FIELD_W-1:0] field
);
  logic [OFS_W-1:SLOT_LSB] slot;
  logic                    unused_byte_bits;

  assign slot             = addr[OFS_W-1:SLOT_LSB];
  assign field            = addr[SLOT_LSB-1:2];
  assign unused_byte_bits = ^addr[1:0];

  localparam logic [OFS_W-1:0] TMR_B = TMR_OFS;

  genvar k;
  generate
    for (k = 0; k < N_OUT; k++) begin : g_out
      localparam logic [OFS_W-1:0] B = out_base(k);
      assign out_hit[k] = (slot == B[OFS_W-1:SLOT_LSB]);
    end
    for (k = 0; k < N_IN; k++) begin : g_in
      localparam logic [OFS_W-1:0] B = in_base(k);
      assign in_hit[k] = (slot == B[OFS_W-1:SLOT_LSB]);
    end
  endgenerate

  assign tmr_hit = (slot == TMR_B[OFS_W-1:SLOT_LSB]) && (field == TMR_B[SLOT_LSB-1:2]);
  assign cfg_hit = (addr[OFS_W-1:2] == '0);
endmodule

// File: rtl/pcib_win_slot.sv
module pcib_win_slot
  import pcib_pkg::*;
#(
  parameter int                    DATA_W = 32,
  parameter logic [N_FIELDS-1:0]   FMASK  = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               we,
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] fld_q [N_FIELDS];

  genvar f;
  generate
    for (f = 0; f < N_FIELDS; f++) begin : g_fld
      if (FMASK[f]) begin : g_reg
        always_ff @(posedge clk) begin
          if (rst)
            fld_q[f] <= '0;
          else if (sel && we && field == FIELD_W'(f))
            fld_q[f] <= wdata;
        end
      end else begin : g_hole
        assign fld_q[f] = '0;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_FIELDS; i++)
      if (sel && field == FIELD_W'(i))
        rdata = fld_q[i];
  end
endmodule

// File: rtl/pcib_irq_swizzle.sv
module pcib_irq_swizzle #(
  parameter int SLOT_FIRST = 17,
  parameter int N_SLOTS    = 2,
  parameter int ROT_REF    = 16,
  parameter int N_LINES    = 4,
  localparam int LINE_W    = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        devfn,
  input  logic [LINE_W-1:0] pin,
  output logic [LINE_W-1:0] line
);
  logic [4:0]        devno;
  logic [LINE_W-1:0] line_d;
  logic              unused_func;
  int                sum;

  assign devno       = devfn[7:3];
  assign unused_func = ^devfn[2:0];

  always_comb begin
    sum    = int'(pin) + int'(devno) - ROT_REF;
    line_d = '0;
    if (int'(devno) >= SLOT_FIRST && int'(devno) < SLOT_FIRST + N_SLOTS)
      line_d = LINE_W'(sum % N_LINES);
  end

  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= line_d;
  end
endmodule

// File: rtl/pcib_winregs.sv
module pcib_winregs
  import pcib_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int N_OUT          = 4,
  parameter int N_IN           = 3,
  parameter int IRQ_SLOT_FIRST = 17,
  parameter int IRQ_N_SLOTS    = 2,
  parameter int IRQ_ROT_REF    = 16,
  parameter int IRQ_LINES      = 4,
  localparam int LINE_W        = $clog2(IRQ_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [7:0]        irq_devfn,
  input  logic [LINE_W-1:0] irq_pin,
  output logic [LINE_W-1:0] irq_line
);
  logic [N_OUT-1:0]   out_hit;
  logic [N_IN-1:0]    in_hit;
  logic               tmr_hit, cfg_hit;
  logic [FIELD_W-1:0] field;
  logic               wr_en, rd_en;
  logic [DATA_W-1:0]  cfg_q, tmr_rd, rd_word;
  logic [DATA_W-1:0]  out_rd [N_OUT];
  logic [DATA_W-1:0]  in_rd  [N_IN];

  assign wr_en = req_valid &  req_write;
  assign rd_en = req_valid & ~req_write;

  pcib_addr_dec #(.N_OUT(N_OUT), .N_IN(N_IN)) u_dec (
    .addr(req_addr), .out_hit(out_hit), .in_hit(in_hit),
    .tmr_hit(tmr_hit), .cfg_hit(cfg_hit), .field(field)
  );

  // configuration address: word aligned
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (wr_en && cfg_hit)
      cfg_q <= {req_wdata[DATA_W-1:2], 2'b00};
  end

  genvar k;
  generate
    for (k = 0; k < N_OUT; k++) begin : g_out
      pcib_win_slot #(.DATA_W(DATA_W), .FMASK(OUT_FIELDS)) u_slot (
        .clk(clk), .rst(rst), .sel(out_hit[k]), .we(wr_en), .field(field),
        .wdata(req_wdata), .rdata(out_rd[k])
      );
    end
    for (k = 0; k < N_IN; k++) begin : g_in
      pcib_win_slot #(.DATA_W(DATA_W), .FMASK(IN_FIELDS)) u_slot (
        .clk(clk), .rst(rst), .sel(in_hit[k]), .we(wr_en), .field(field),
        .wdata(req_wdata), .rdata(in_rd[k])
      );
    end
  endgenerate

  pcib_win_slot #(.DATA_W(DATA_W), .FMASK(TMR_FIELDS)) u_tmr (
    .clk(clk), .rst(rst), .sel(tmr_hit), .we(wr_en), .field(field),
    .wdata(req_wdata), .rdata(tmr_rd)
  );

  // hits are exclusive; unselected slots return zero
  always_comb begin
    rd_word = cfg_hit ? cfg_q : '0;
    for (int i = 0; i < N_OUT; i++) rd_word = rd_word | out_rd[i];
    for (int i = 0; i < N_IN; i++)  rd_word = rd_word | in_rd[i];
    rd_word = rd_word | tmr_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)        rsp_rdata <= '0;
    else if (rd_en) rsp_rdata <= rd_word;
  end

  pcib_irq_swizzle #(
    .SLOT_FIRST(IRQ_SLOT_FIRST), .N_SLOTS(IRQ_N_SLOTS),
    .ROT_REF(IRQ_ROT_REF), .N_LINES(IRQ_LINES)
  ) u_irq (
    .clk(clk), .rst(rst), .devfn(irq_devfn), .pin(irq_pin), .line(irq_line)
  );
endmodule

// File: rtl/pcib_winregs_chk.sv
module pcib_winregs_chk #(
  parameter int DATA_W = 32,
  parameter int LINE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [11:0]       req_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [7:0]        irq_devfn,
  input logic [LINE_W-1:0] irq_line
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^{req_addr[1:0], irq_devfn[2:0]};

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> $stable(rsp_rdata));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(rsp_rdata));

  assert_cfg_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[11:2] == 10'd0) |=> rsp_rdata[1:0] == 2'b00);

  assert_high_index_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[4:2] > 3'd4) |=> rsp_rdata == '0);

  assert_cfgdata_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[11:2] == 10'd1) |=> rsp_rdata == '0);

  assert_other_dev_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_devfn[7:3] != 5'h11 && irq_devfn[7:3] != 5'h12) |=> irq_line == '0);
endmodule

bind pcib_winregs pcib_winregs_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_rdata(rsp_rdata), .irq_devfn(irq_devfn),
  .irq_line(irq_line)
);

// File: tb/pcib_winregs_tb.sv
`timescale 1ns/1ps
module pcib_winregs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [7:0]  irq_devfn = '0;
  logic [1:0]  irq_pin = '0;
  logic [1:0]  irq_line;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mdl [1024];

  always #2 clk = ~clk;

  pcib_winregs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_devfn(irq_devfn), .irq_pin(irq_pin), .irq_line(irq_line)
  );

  // register map taken from the requirements (R3, R4, R5, R7, R8)
  function automatic bit mapped(input logic [11:0] a);
    logic [6:0] s; logic [2:0] f;
    s = a[11:5]; f = a[4:2];
    if (a[11:2] == 10'd0) return 1;
    if (s >= 7'h61 && s <= 7'h64 && (f == 0 || f == 1 || f == 2 || f == 4)) return 1;
    if (s >= 7'h6D && s <= 7'h6F && (f == 0 || f == 2 || f == 3 || f == 4)) return 1;
    if (s == 7'h71 && f == 0) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] exp_line(input logic [7:0] dfn, input logic [1:0] p);
    int dn;
    dn = int'(dfn[7:3]);
    if (dn == 17 || dn == 18) return 2'((int'(p) + dn - 16) % 4);
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (mapped(a)) mdl[a[11:2]] = (a[11:2] == 10'd0) ? {d[31:2], 2'b00} : d;
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(req, rsp_rdata, mapped(a) ? mdl[a[11:2]] : 32'h0);
  endtask

  task automatic irq_chk(input logic [7:0] dfn, input logic [1:0] p, input string req);
    @(negedge clk);
    irq_devfn = dfn; irq_pin = p;
    @(negedge clk);
    check(req, {30'd0, irq_line}, {30'd0, exp_line(dfn, p)});
  endtask

  function automatic logic [11:0] pick_addr();
    int r;
    logic [2:0] fo[4], fi[4];
    fo = '{3'd0, 3'd1, 3'd2, 3'd4};
    fi = '{3'd0, 3'd2, 3'd3, 3'd4};
    r = $urandom % 8;
    case (r)
      0: return 12'($urandom % 4);
      1, 2: return 12'hC20 + 12'(($urandom % 4) * 32) + {7'd0, fo[$urandom % 4], 2'($urandom)};
      3, 4: return 12'hDA0 + 12'(($urandom % 3) * 32) + {7'd0, fi[$urandom % 4], 2'($urandom)};
      5: return 12'hE20 + 12'($urandom % 32);
      6: return {2'b11, 10'($urandom)};
      default: return 12'($urandom);
    endcase
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rsp after reset", rsp_rdata, 32'h0);
    check("R1 irq after reset", {30'd0, irq_line}, 32'h0);
    rd_chk(12'h000, "R1 cfg reset");
    rd_chk(12'hC30, "R1 outbound reset");
    rd_chk(12'hDF0, "R1 inbound reset");
    rd_chk(12'hE20, "R1 timer reset");

    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk(12'h000, "R3 cfg low bits cleared");
    wr(12'h000, 32'h8000_1237);
    rd_chk(12'h000, "R3 cfg readback");

    wr(12'hC20, 32'h1111_0000); wr(12'hC24, 32'h2222_0000);
    wr(12'hC28, 32'h3333_0000); wr(12'hC30, 32'h4444_0000);
    rd_chk(12'hC20, "R4 outbound +0x0"); rd_chk(12'hC24, "R4 outbound +0x4");
    rd_chk(12'hC28, "R4 outbound +0x8"); rd_chk(12'hC30, "R6 outbound +0x10 separate");
    wr(12'hC80, 32'hABCD_0004);
    rd_chk(12'hC80, "R4 outbound window 4");

    wr(12'hDE0, 32'h5555_0001); wr(12'hDF0, 32'h6666_0001);
    wr(12'hDAC, 32'h7777_0003); wr(12'hDC8, 32'h8888_0002);
    rd_chk(12'hDE0, "R6 inbound +0x0 separate"); rd_chk(12'hDF0, "R5 inbound +0x10");
    rd_chk(12'hDAC, "R5 inbound 3 +0xC"); rd_chk(12'hDC8, "R5 inbound 2 +0x8");

    wr(12'hE20, 32'hDEAD_BEEF);
    rd_chk(12'hE20, "R7 timer readback");
    wr(12'hE24, 32'h0BAD_0BAD);
    rd_chk(12'hE24, "R8 timer neighbour reads zero");
    rd_chk(12'hE20, "R8 timer untouched");
    wr(12'hC2C, 32'hFFFF_FFFF);
    rd_chk(12'hC2C, "R8 outbound +0xC hole");
    wr(12'hDE4, 32'hFFFF_FFFF);
    rd_chk(12'hDE4, "R8 inbound +0x4 hole");
    wr(12'h004, 32'h1234_5678);
    rd_chk(12'h004, "R8 data port reads zero");
    rd_chk(12'h000, "R8 cfg untouched by 0x004");

    wr(12'hC43, 32'hCAFE_F00D);
    rd_chk(12'hC40, "R9 low bits ignored on write");
    rd_chk(12'hC42, "R9 low bits ignored on read");

    rd_chk(12'hE20, "R2 setup read");
    held = rsp_rdata;
    wr(12'hC44, 32'h0000_0001);
    check("R2 hold over write", rsp_rdata, held);
    @(negedge clk);
    check("R2 hold over idle", rsp_rdata, held);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      a = pick_addr();
      if ($urandom % 2) wr(a, $urandom);
      else rd_chk(a, "R4 R5 R8 random access");
    end
    for (int i = 0; i < 1024; i++) rd_chk(12'(i * 4), "R8 full sweep");

    for (int p = 0; p < 4; p++) begin
      irq_chk({5'h11, 3'd0}, 2'(p), "R10 slot 0x11");
      irq_chk({5'h12, 3'd5}, 2'(p), "R10 slot 0x12");
      irq_chk({5'h10, 3'd0}, 2'(p), "R11 device 0x10");
      irq_chk({5'h13, 3'd0}, 2'(p), "R11 device 0x13");
    end
    for (int i = 0; i < 300; i++)
      irq_chk(8'($urandom), 2'($urandom), "R10 R11 random");

    done = 1;
    summary();
    $finish;
  end
endmodule